// File: doc/BRIEF.md
# Slow-Infrared Pulse Codec

This block sits between a byte-oriented link layer and an infrared transceiver running at slow-infrared rates. On the transmit side it accepts bytes over a valid/ready handshake and frames each one as asynchronous 8N1: a start zero, eight data bits least significant first, and a stop one. Every zero bit is emitted on the LED output as a single short pulse at the start of its bit cell. A one bit leaves the LED dark. A 6-bit divisor sets the bit rate to 115200/(D+1), which gives 115200, 57600, 38400, 19200 and 9600 baud for divisors 0, 1, 2, 5 and 11. A separate 5-bit value sets the pulse width.

The receive side takes the photodiode line, inverts it if asked, synchronises it, and rebuilds bytes from the pulse pattern. A bit cell that holds a pulse decodes as zero. A pulse inside the stop cell flags a framing error. Both directions count in base ticks, which are sixteen times 115200 Hz and are supplied as a clock-enable. A single physical-layer enable gates the whole block. While that enable is low the LED rests at its idle level and no byte is received.

Top module: `sir_pulse_codec`

## Requirements
- R1: After reset, with `phy_en` high and `tx_inv` low, `led_tx` is 0, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A transmitted frame is ten bit cells, each lasting 16*(`baud_div`+1) base ticks. Cell 0 is the start bit (0), cells 1 to 8 carry data bit 0 to bit 7, and cell 9 is the stop bit (1).
- R3: Each zero bit produces exactly one LED pulse of `pulse_w` base ticks, beginning at the start of its cell. A one bit produces none.
- R4: A byte is taken only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low from that cycle until the frame's stop cell has ended.
- R5: `tx_inv` = 1 inverts `led_tx`, including its idle level (idle is `led_tx` = `tx_inv`).
- R6: While `phy_en` is low, `led_tx` sits at its idle level, `tx_ready` is low, a frame in progress is abandoned, and no `rx_valid` is produced.
- R7: Bit-cell counters advance only on cycles with `tick_en` high. Cell length in clock cycles therefore scales with the tick spacing.
- R8: In the receiver, the rising edge of a pulse while idle opens a frame. Each later cell decodes as 0 if a pulse rises in it and as 1 otherwise. The byte appears on `rx_data` with `rx_valid` high for exactly one cycle.
- R9: A pulse in the stop cell sets `rx_frame_err` high in the same cycle as `rx_valid`. `rx_frame_err` is never high without `rx_valid`.
- R10: `rx_inv` = 1 treats a low level on `led_rx` as a pulse.
- R11: The divisor and pulse width are captured when a frame starts. Changing them mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base tick enable, 16 x 115200 Hz |
| phy_en | input | 1 | Physical layer enable |
| baud_div | input | 6 | Bit-rate divisor D, rate 115200/(D+1) |
| pulse_w | input | 5 | Pulse width in base ticks |
| tx_inv | input | 1 | Invert transmit LED |
| rx_inv | input | 1 | Invert receive line |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be taken |
| led_tx | output | 1 | Transmit LED drive |
| led_rx | input | 1 | Receive photodiode line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_frame_err | output | 1 | Stop cell held a pulse |

## Verification
In loopback, the receiver is still finishing one frame while the transmitter is already starting the next. The handshake can accept a new byte in the same cycle that the receiver's stop-cell window closes and raises `rx_valid`. The bench provokes this by streaming bytes back to back with `tx_valid` held high, so each accept lands beside a receive completion. A scoreboard queue, filled at accept time, judges every decoded byte, and a width monitor checks every LED pulse at the same time. Dropping `phy_en` in the middle of a frame hits both directions at once. It is judged by the idle LED level and by the absence of any unexpected `rx_valid`.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_STOP} rx_state_e;
endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic inv,
  output logic q
);
  logic [STAGES-1:0] ff;
  always_ff @(posedge clk) begin
    if (rst) ff <= '0;
    else     ff <= {ff[STAGES-2:0], d};
  end
  assign q = ff[STAGES-1] ^ inv;
endmodule

// File: rtl/sir_tx_mod.sv
module sir_tx_mod #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6,
  parameter int PW_W   = 5,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              phy_en,
  input  logic              inv,
  input  logic [DIV_W-1:0]  div,
  input  logic [PW_W-1:0]   pw,
  input  logic [DATA_W-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              led
);
  localparam int CNT_W = $clog2(OVS * (2 ** DIV_W));
  localparam int NBITS = DATA_W + 2;
  localparam int IDX_W = $clog2(NBITS + 1);

  logic              busy;
  logic [NBITS-1:0]  shreg;
  logic [CNT_W-1:0]  cnt, last;
  logic [PW_W-1:0]   pw_q;
  logic [IDX_W-1:0]  idx;
  logic              pulse;

  assign ready = phy_en & ~busy;
  assign pulse = busy & ~shreg[0] & (cnt < CNT_W'(pw_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
      last  <= '0;
      pw_q  <= '0;
      idx   <= '0;
      led   <= 1'b0;
    end else begin
      led <= phy_en ? (pulse ^ inv) : inv;
      if (!phy_en) begin
        busy <= 1'b0;
      end else if (valid && ready) begin
        busy  <= 1'b1;
        shreg <= {1'b1, data, 1'b0};
        cnt   <= '0;
        idx   <= '0;
        last  <= CNT_W'(div) * CNT_W'(OVS) + CNT_W'(OVS - 1);
        pw_q  <= pw;
      end else if (busy && tick) begin
        if (cnt == last) begin
          cnt   <= '0;
          shreg <= {1'b1, shreg[NBITS-1:1]};
          idx   <= idx + 1'b1;
          if (idx == IDX_W'(NBITS - 1)) busy <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sir_rx_demod.sv
module sir_rx_demod
  import sir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              phy_en,
  input  logic              line,
  input  logic [DIV_W-1:0]  div,
  output logic [DATA_W-1:0] data,
  output logic              valid,
  output logic              ferr
);
  localparam int CNT_W = $clog2(OVS * (2 ** DIV_W));
  localparam int IDX_W = $clog2(DATA_W + 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt, last, half;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              prev, seen, seen_nx;
  logic              rise, early, seen_now, nx_now;

  assign rise     = line & ~prev;
  assign early    = cnt < half;
  assign seen_now = seen | (rise & early);
  assign nx_now   = seen_nx | (rise & ~early);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      last    <= '0;
      half    <= '0;
      idx     <= '0;
      shreg   <= '0;
      prev    <= 1'b1;
      seen    <= 1'b0;
      seen_nx <= 1'b0;
      data    <= '0;
      valid   <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      prev  <= line;
      valid <= 1'b0;
      ferr  <= 1'b0;
      if (!phy_en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: begin
            if (rise) begin
              state   <= RX_BITS;
              cnt     <= '0;
              idx     <= '0;
              seen    <= 1'b0;
              seen_nx <= 1'b0;
              last    <= CNT_W'(div) * CNT_W'(OVS) + CNT_W'(OVS - 1);
              half    <= CNT_W'(div) * CNT_W'(OVS / 2) + CNT_W'(OVS / 2);
            end
          end
          RX_BITS: begin
            if (tick && cnt == last) begin
              cnt     <= '0;
              seen    <= nx_now;
              seen_nx <= 1'b0;
              if (idx != '0) shreg <= {~seen_now, shreg[DATA_W-1:1]};
              idx <= idx + 1'b1;
              if (idx == IDX_W'(DATA_W)) state <= RX_STOP;
            end else begin
              seen    <= seen_now;
              seen_nx <= nx_now;
              if (tick) cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (tick && cnt == half - 1'b1) begin
              valid <= 1'b1;
              data  <= shreg;
              ferr  <= seen_now;
              state <= RX_IDLE;
            end else begin
              seen <= seen_now;
              if (tick) cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sir_pulse_codec.sv
module sir_pulse_codec #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6,
  parameter int PW_W   = 5,
  parameter int OVS    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              phy_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [PW_W-1:0]   pulse_w,
  input  logic              tx_inv,
  input  logic              rx_inv,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              led_tx,
  input  logic              led_rx,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err
);
  logic rx_line;

  sir_tx_mod #(.DATA_W(DATA_W), .DIV_W(DIV_W), .PW_W(PW_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick_en), .phy_en(phy_en), .inv(tx_inv),
    .div(baud_div), .pw(pulse_w), .data(tx_data), .valid(tx_valid),
    .ready(tx_ready), .led(led_tx)
  );

  sir_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(led_rx), .inv(rx_inv), .q(rx_line)
  );

  sir_rx_demod #(.DATA_W(DATA_W), .DIV_W(DIV_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick_en), .phy_en(phy_en), .line(rx_line),
    .div(baud_div), .data(rx_data), .valid(rx_valid), .ferr(rx_frame_err)
  );
endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk (
  input logic clk,
  input logic rst,
  input logic phy_en,
  input logic tx_inv,
  input logic tx_valid,
  input logic tx_ready,
  input logic led_tx,
  input logic rx_valid,
  input logic rx_frame_err
);
  a_r6_led_idle_off: assert property (@(posedge clk) disable iff (rst)
    !phy_en |=> led_tx == $past(tx_inv));
  a_r6_no_rx_off: assert property (@(posedge clk) disable iff (rst)
    !phy_en |=> !rx_valid);
  a_r4_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> !tx_ready);
  a_r5_idle_level: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> led_tx == $past(tx_inv));
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r9_err_with_valid: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |-> rx_valid);
endmodule

bind sir_pulse_codec sir_codec_chk i_chk (
  .clk(clk), .rst(rst), .phy_en(phy_en), .tx_inv(tx_inv), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .led_tx(led_tx), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
);

// File: tb/test_sir_pulse_codec.sv
module test_sir_pulse_codec;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b1;
  logic phy_en = 1'b1;
  logic [5:0] baud_div = 6'd0;
  logic [4:0] pulse_w = 5'd12;
  logic tx_inv = 1'b0, rx_inv = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;
  logic tx_ready, led_tx, led_rx, rx_valid, rx_frame_err;
  logic [7:0] rx_data;
  logic loop = 1'b1, man_line = 1'b0;

  always #2 clk = ~clk;

  assign led_rx = loop ? (led_tx ^ tx_inv ^ rx_inv) : man_line;

  sir_pulse_codec i_sir_pulse_codec (
    .clk(clk), .rst(rst), .tick_en(tick_en), .phy_en(phy_en), .baud_div(baud_div),
    .pulse_w(pulse_w), .tx_inv(tx_inv), .rx_inv(rx_inv), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .led_tx(led_tx), .led_rx(led_rx),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  typedef struct { logic [7:0] d; logic e; string tag; } exp_t;
  exp_t sb_q[$];
  int rises[$];
  int n_chk = 0, n_fail = 0, n_rx = 0;
  int tick_per = 1, exp_pw = 12, cyc = 0;
  bit chk_w = 1'b1, mon_en = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // base tick generator
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      tick_en = (tick_per == 1) || (t % tick_per == 0);
    end
  end

  // LED pulse monitor: width and rise times
  initial begin
    bit vprev = 1'b0;
    int run = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!mon_en) begin
        vprev = 1'b0; run = 0;
      end else begin
        bit v;
        v = led_tx ^ tx_inv;
        if (v && !vprev) rises.push_back(cyc);
        if (v) run++;
        if (!v && vprev) begin
          if (chk_w) check(run == exp_pw, "R3 pulse width", run, exp_pw);
          run = 0;
        end
        vprev = v;
      end
    end
  end

  // receive scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        n_rx++;
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 unexpected byte", int'(rx_data), -1);
        end else begin
          exp_t x;
          x = sb_q.pop_front();
          check(rx_data == x.d, {x.tag, " rx data"}, int'(rx_data), int'(x.d));
          check(rx_frame_err == x.e, {x.tag, " frame err"}, int'(rx_frame_err), int'(x.e));
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit expect_rx, input string tag);
    exp_t x;
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    if (expect_rx) begin
      x.d = b; x.e = 1'b0; x.tag = tag;
      sb_q.push_back(x);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic set_phy_off_cfg(input bit ti, input bit ri);
    @(negedge clk);
    mon_en = 1'b0; phy_en = 1'b0;
    repeat (3) @(negedge clk);
    tx_inv = ti; rx_inv = ri;
    repeat (4) @(negedge clk);
    phy_en = 1'b1;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
  endtask

  // bench-driven frame on the receive line, 16 clocks per cell
  task automatic raw_frame(input logic [7:0] b, input bit stop_bit, input bit err);
    logic [9:0] bits;
    exp_t x;
    bits = {stop_bit, b, 1'b0};
    x.d = b; x.e = err; x.tag = "R9";
    sb_q.push_back(x);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      man_line = ~bits[i];
      repeat (4) @(negedge clk);
      man_line = 1'b0;
      repeat (11) @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(led_tx == 1'b0, "R1 led idle", int'(led_tx), 0);
    check(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
    check(rx_valid == 1'b0, "R1 no rx", int'(rx_valid), 0);

    // loopback stream at divisor 1, back to back
    baud_div = 6'd1; pulse_w = 5'd12; exp_pw = 12;
    send(8'hA5, 1'b1, "R8");
    send(8'h3C, 1'b1, "R8");
    send(8'h00, 1'b1, "R8");
    send(8'hFF, 1'b1, "R8");
    wait_done();

    // cell timing: 0xF9 gives pulses in cells 0, 2, 3
    rises.delete();
    send(8'hF9, 1'b1, "R2");
    wait_done();
    check(rises.size() == 3, "R3 pulse count", rises.size(), 3);
    if (rises.size() == 3) begin
      check(rises[1] - rises[0] == 64, "R2 cell 0 to 2", rises[1] - rises[0], 64);
      check(rises[2] - rises[1] == 32, "R2 cell 2 to 3", rises[2] - rises[1], 32);
    end

    // slowest rate, divisor 11
    baud_div = 6'd11;
    rises.delete();
    send(8'h5A, 1'b1, "R2");
    wait_done();
    check(rises.size() == 5, "R2 pulse count at div 11", rises.size(), 5);
    if (rises.size() >= 2)
      check(rises[1] - rises[0] == 192, "R2 cell at div 11", rises[1] - rises[0], 192);

    // handshake and capture of settings at frame start
    baud_div = 6'd1; pulse_w = 5'd12; exp_pw = 12;
    send(8'h81, 1'b1, "R11");
    repeat (40) @(negedge clk);
    check(tx_ready == 1'b0, "R4 busy mid frame", int'(tx_ready), 0);
    baud_div = 6'd0; pulse_w = 5'd3;
    wait_done();
    check(sb_q.size() == 0, "R11 byte delivered", sb_q.size(), 0);

    // inverted directions
    pulse_w = 5'd5; exp_pw = 5;
    set_phy_off_cfg(1'b1, 1'b1);
    check(led_tx == 1'b1, "R5 inverted idle", int'(led_tx), 1);
    send(8'h96, 1'b1, "R10");
    send(8'h69, 1'b1, "R10");
    wait_done();

    // phy disable mid frame
    set_phy_off_cfg(1'b0, 1'b0);
    baud_div = 6'd1; pulse_w = 5'd12; exp_pw = 12;
    base = n_rx;
    send(8'h00, 1'b0, "R6");
    repeat (50) @(negedge clk);
    mon_en = 1'b0; phy_en = 1'b0;
    repeat (2) @(negedge clk);
    check(led_tx == 1'b0, "R6 led idle", int'(led_tx), 0);
    check(tx_ready == 1'b0, "R6 not ready", int'(tx_ready), 0);
    repeat (40) @(negedge clk);
    phy_en = 1'b1;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    repeat (400) @(negedge clk);
    check(n_rx == base, "R6 no byte after abort", n_rx - base, 0);
    check(tx_ready == 1'b1, "R6 ready again", int'(tx_ready), 1);
    check(led_tx == 1'b0, "R6 line quiet", int'(led_tx), 0);

    // sparse ticks: one tick every 3 clocks
    tick_per = 3; chk_w = 1'b0;
    baud_div = 6'd0; pulse_w = 5'd4;
    repeat (6) @(negedge clk);
    rises.delete();
    send(8'hF9, 1'b1, "R7");
    wait_done();
    check(rises.size() == 3, "R7 pulse count", rises.size(), 3);
    if (rises.size() == 3)
      check(rises[2] - rises[1] == 48, "R7 cell length", rises[2] - rises[1], 48);
    tick_per = 1;
    repeat (6) @(negedge clk);
    chk_w = 1'b1;

    // framing error from a bench-driven line
    loop = 1'b0; man_line = 1'b0;
    baud_div = 6'd0;
    repeat (10) @(negedge clk);
    raw_frame(8'h3E, 1'b0, 1'b1);
    raw_frame(8'hC1, 1'b1, 1'b0);
    loop = 1'b1;

    repeat (20) @(negedge clk);
    check(sb_q.size() == 0, "R8 all bytes seen", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule